// File: doc/BRIEF.md
# Sequential Integer Divider with Overflow Trap

This block is the iterative divide unit of a processor datapath. It divides a dividend twice as wide as the operand size by a divisor of the operand size, treating both as unsigned or as two's complement numbers. The operand size is 8, 16, 32 or 64 bits. The caller presents an accumulator word and a high word together with the divisor and pulses `start_i`. The block returns the quotient and remainder already packed into the accumulator and high words, so the caller can write them back unchanged.

A division by zero, or a quotient that does not fit the operand size, raises `div_err_o` in the cycle of `done_o` in place of a result. Two error cases are caught before any iteration: a zero divisor, and a dividend whose upper half (in magnitude) is already at least the divisor. Both finish one cycle after the start. A valid division runs one restoring step per operand bit. In signed mode the sign is stripped before the loop and applied again after it, and the signed range check is made on the result.

The parameter `XLEN` is the widest operand size and must be 64 to support all four size codes.

Top module: `div_seq`

## Requirements
- R1: With `size_i` = 0 (8-bit), the dividend is `acc_i[15:0]`. On success `acc_o[7:0]` holds the quotient and `acc_o[15:8]` holds the remainder. `acc_o[XLEN-1:16]` equals `acc_i[XLEN-1:16]` and `hi_o` equals `hi_i`, both as captured at start.
- R2: With `size_i` = 1, 2 or 3 (n = 16, 32, 64 bits), the dividend is `{hi_i[n-1:0], acc_i[n-1:0]}`. On success the quotient is in `acc_o[n-1:0]` and the remainder in `hi_o[n-1:0]`. Bits of `acc_o` and `hi_o` above n equal the captured inputs.
- R3: In unsigned mode (`signed_i` = 0), `div_err_o` is raised when the quotient is 2^n or larger. This includes every case where the dividend's upper half is at least the divisor.
- R4: A divisor whose low n bits are zero raises `div_err_o` with `done_o` one cycle after the start is accepted.
- R5: In signed mode (`signed_i` = 1), the quotient is truncated toward zero. The remainder has the sign of the dividend, and dividend = quotient × divisor + remainder.
- R6: In signed mode, `div_err_o` is raised when the true quotient lies outside [-2^(n-1), 2^(n-1)-1]. A quotient of exactly -2^(n-1) is a valid result.
- R7: An error caught before iterating (R4, or the magnitude of the dividend's upper half being at least the magnitude of the divisor) gives `done_o` one cycle after the start edge. Every other operation gives `done_o` exactly n+1 cycles after it.
- R8: `done_o` is a single-cycle pulse. `busy_o` is high from the cycle after the start edge through the `done_o` cycle. `div_err_o` is low whenever `done_o` is low.
- R9: `start_i` is ignored while `busy_o` is high. A second start during an operation changes neither its result nor its timing.
- R10: After `done_o`, `acc_o` and `hi_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; sampled only while idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| size_i | input | 2 | Operand size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| acc_i | input | XLEN | Accumulator word (low half of dividend; whole dividend at 8 bits) |
| hi_i | input | XLEN | High word (upper half of dividend for 16/32/64 bits) |
| divisor_i | input | XLEN | Divisor, low n bits used |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error, valid with done_o |
| acc_o | output | XLEN | Packed accumulator result |
| hi_o | output | XLEN | Packed high-word result |

## Verification
A wrong restoring step corrupts a quotient bit or the partial remainder. This shows at the ports as a quotient/remainder pair that breaks the division identity when `done_o` rises, n+1 cycles after start. A wrong sign or range decision shows as an error flag on a valid result or a missing flag on an overflow, often only at the ±2^(n-1) boundaries. A wrong iteration counter or state machine shows as `done_o` in the wrong cycle, checked against the exact latency expected for each case. The bench sweeps 8-bit divisors and dividends densely in both modes, including the sign boundary values, and applies pseudo-random and corner operands at the wider sizes.

// File: rtl/div_seq_pkg.sv
package div_seq_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} op_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} div_state_e;

  function automatic int unsigned op_bits(logic [1:0] sz);
    return 32'd8 << sz;
  endfunction
endpackage

// File: rtl/div_seq_prep.sv
module div_seq_prep
  import div_seq_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            signed_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic [XLEN-1:0] rem_init_o,
  output logic [XLEN-1:0] low_init_o,
  output logic [XLEN-1:0] dmag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            early_err_o
);
  localparam int unsigned W2 = 2 * XLEN;

  always_comb begin
    int unsigned n;
    logic [W2-1:0]   mask2, dvd, mag;
    logic [XLEN-1:0] maskn, dv, mhi, mlo;
    logic            sa, sb;
    n     = op_bits(size_i);
    maskn = ~({XLEN{1'b1}} << n);
    mask2 = ~({W2{1'b1}} << (2 * n));
    if (size_i == SZ_B) dvd = {{(W2-16){1'b0}}, acc_i[15:0]};
    else                dvd = ({{XLEN{1'b0}}, hi_i & maskn} << n) | {{XLEN{1'b0}}, acc_i & maskn};
    dv    = divisor_i & maskn;
    // sign bits found by masking, avoids a variable bit select
    sa    = signed_i & (|(dvd & ~(mask2 >> 1)));
    sb    = signed_i & (|(dv & ~(maskn >> 1)));
    mag   = sa ? ((~dvd + 1'b1) & mask2) : dvd;
    dmag_o = sb ? ((~dv + 1'b1) & maskn) : dv;
    mhi   = XLEN'(mag >> n);
    mlo   = XLEN'(mag) & maskn;
    rem_init_o  = mhi;
    low_init_o  = mlo << (XLEN - n);  // left-justify so the next bit is always the MSB
    neg_q_o     = sa ^ sb;
    neg_r_o     = sa;
    early_err_o = (dv == '0) || (mhi >= dmag_o);
  end
endmodule

// File: rtl/div_seq_core.sv
module div_seq_core #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] rem_init_i,
  input  logic [XLEN-1:0] low_init_i,
  input  logic [XLEN-1:0] dmag_i,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] low_o
);
  logic [XLEN-1:0] rem_q, low_q, d_q, rem_nx, low_nx;
  logic [XLEN:0]   rem_ext;
  logic            fit;

  always_comb begin
    rem_ext = {rem_q, low_q[XLEN-1]};
    fit     = rem_ext >= {1'b0, d_q};
    // partial remainder stays below the divisor, so XLEN bits hold the difference
    rem_nx  = fit ? (rem_ext[XLEN-1:0] - d_q) : rem_ext[XLEN-1:0];
    low_nx  = {low_q[XLEN-2:0], fit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      low_q <= '0;
      d_q   <= '0;
    end else if (load_i) begin
      rem_q <= rem_init_i;
      low_q <= low_init_i;
      d_q   <= dmag_i;
    end else if (step_i) begin
      rem_q <= rem_nx;
      low_q <= low_nx;
    end
  end

  assign rem_o = rem_q;
  assign low_o = low_q;
endmodule

// File: rtl/div_seq_post.sv
module div_seq_post
  import div_seq_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            signed_i,
  input  logic [1:0]      size_i,
  input  logic            neg_q_i,
  input  logic            neg_r_i,
  input  logic [XLEN-1:0] rem_i,
  input  logic [XLEN-1:0] low_i,
  input  logic [XLEN-1:0] acc_keep_i,
  input  logic [XLEN-1:0] hi_keep_i,
  output logic [XLEN-1:0] acc_o,
  output logic [XLEN-1:0] hi_o,
  output logic            late_err_o
);
  always_comb begin
    int unsigned n;
    logic [XLEN-1:0] maskn, qm, half, q, r;
    n     = op_bits(size_i);
    maskn = ~({XLEN{1'b1}} << n);
    qm    = low_i & maskn;
    half  = {{(XLEN-1){1'b0}}, 1'b1} << (n - 1);
    late_err_o = signed_i && (neg_q_i ? (qm > half) : (qm >= half));
    q = neg_q_i ? ((~qm + 1'b1) & maskn) : qm;
    r = neg_r_i ? ((~rem_i + 1'b1) & maskn) : (rem_i & maskn);
    if (size_i == SZ_B) begin
      acc_o = {acc_keep_i[XLEN-1:16], r[7:0], q[7:0]};
      hi_o  = hi_keep_i;
    end else begin
      acc_o = (acc_keep_i & ~maskn) | q;
      hi_o  = (hi_keep_i & ~maskn) | r;
    end
  end
endmodule

// File: rtl/div_seq.sv
module div_seq
  import div_seq_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            signed_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] divisor_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            div_err_o,
  output logic [XLEN-1:0] acc_o,
  output logic [XLEN-1:0] hi_o
);
  localparam int unsigned CW = $clog2(XLEN) + 1;

  div_state_e      state_q;
  logic [CW-1:0]   cnt_q, last_q;
  logic            sg_q, neg_q_q, neg_r_q, err_q;
  logic [1:0]      size_q;
  logic [XLEN-1:0] acc_q, hi_q;

  logic [XLEN-1:0] rem_init, low_init, dmag, rem, low;
  logic            neg_q, neg_r, early_err, late_err, accept, load, step;

  div_seq_prep #(.XLEN(XLEN)) u_prep (
    .signed_i   (signed_i),
    .size_i     (size_i),
    .acc_i      (acc_i),
    .hi_i       (hi_i),
    .divisor_i  (divisor_i),
    .rem_init_o (rem_init),
    .low_init_o (low_init),
    .dmag_o     (dmag),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r),
    .early_err_o(early_err)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && !early_err;
  assign step   = (state_q == ST_RUN);

  div_seq_core #(.XLEN(XLEN)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .rem_init_i(rem_init),
    .low_init_i(low_init),
    .dmag_i    (dmag),
    .rem_o     (rem),
    .low_o     (low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      sg_q    <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= '0;
      acc_q   <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          sg_q    <= signed_i;
          size_q  <= size_i;
          neg_q_q <= neg_q;
          neg_r_q <= neg_r;
          acc_q   <= acc_i;
          hi_q    <= hi_i;
          err_q   <= early_err;
          cnt_q   <= '0;
          last_q  <= CW'(op_bits(size_i) - 1);
          state_q <= early_err ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == last_q) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  div_seq_post #(.XLEN(XLEN)) u_post (
    .signed_i  (sg_q),
    .size_i    (size_q),
    .neg_q_i   (neg_q_q),
    .neg_r_i   (neg_r_q),
    .rem_i     (rem),
    .low_i     (low),
    .acc_keep_i(acc_q),
    .hi_keep_i (hi_q),
    .acc_o     (acc_o),
    .hi_o      (hi_o),
    .late_err_o(late_err)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign div_err_o = done_o && (err_q || late_err);
endmodule

// File: rtl/div_seq_chk.sv
module div_seq_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [XLEN-1:0] divisor_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            div_err_o,
  input logic [XLEN-1:0] acc_o,
  input logic [XLEN-1:0] hi_o
);
  localparam int unsigned CW = $clog2(XLEN) + 2;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> done_o);
  a_r8_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r4_zero_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_err_o));
  a_r9_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(acc_o) && $stable(hi_o)));
  a_r7_latency_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt <= CW'(XLEN)));
endmodule

bind div_seq div_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .divisor_i(divisor_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .div_err_o(div_err_o),
  .acc_o    (acc_o),
  .hi_o     (hi_o)
);

// File: tb/div_seq_tb.sv
module div_seq_tb;
  localparam int unsigned XLEN = 64;
  localparam time CLK_PERIOD = 10ns;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            signed_i = 1'b0;
  logic [1:0]      size_i = '0;
  logic [XLEN-1:0] acc_i = '0, hi_i = '0, divisor_i = '0;
  logic            busy_o, done_o, div_err_o;
  logic [XLEN-1:0] acc_o, hi_o;

  int unsigned n_chk = 0, n_fail = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  div_seq #(.XLEN(XLEN)) u_dut (.*);

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic sg, input logic [1:0] sz, input logic [63:0] acc,
                        input logic [63:0] hi, input logic [63:0] dv, input bit poke);
    int n, lat, exp_lat;
    logic [127:0] dvd, uq, ur;
    logic [63:0]  maskn, dvv, q, r, acc_e, hi_e, hold_a, hold_h;
    logic [129:0] t;
    logic signed [129:0] sa, sb, sq, sr, aa, ab, lim;
    bit err;
    string rv, re;
    n     = 8 << sz;
    maskn = (n == 64) ? '1 : ((64'd1 << n) - 1);
    dvd   = (sz == 0) ? {112'd0, acc[15:0]} : ((({64'd0, hi & maskn}) << n) | {64'd0, acc & maskn});
    dvv   = dv & maskn;
    t  = {2'b00, dvd} << (130 - 2*n);  sa = $signed(t) >>> (130 - 2*n);
    t  = {66'd0, dvv} << (130 - n);    sb = $signed(t) >>> (130 - n);
    q = '0; r = '0;
    rv = (sz == 0) ? (sg ? "R1/R5" : "R1") : (sg ? "R2/R5" : "R2");
    re = (dvv == 0) ? "R4" : (sg ? "R6" : "R3");
    if (dvv == 0) begin
      err = 1; exp_lat = 1;
    end else if (sg) begin
      sq = sa / sb; sr = sa % sb;
      lim = 130'sd1 <<< (n - 1);
      err = (sq < -lim) || (sq > lim - 1);
      aa = (sa < 0) ? -sa : sa;  ab = (sb < 0) ? -sb : sb;
      exp_lat = ((aa >>> n) >= ab) ? 1 : n + 1;
      q = sq[63:0] & maskn; r = sr[63:0] & maskn;
    end else begin
      uq = dvd / {64'd0, dvv}; ur = dvd % {64'd0, dvv};
      err = (uq >> n) != 0;
      exp_lat = ((dvd >> n) >= {64'd0, dvv}) ? 1 : n + 1;
      q = uq[63:0]; r = ur[63:0];
    end
    if (sz == 0) begin acc_e = {acc[63:16], r[7:0], q[7:0]}; hi_e = hi; end
    else begin acc_e = (acc & ~maskn) | q; hi_e = (hi & ~maskn) | r; end

    @(negedge clk_i);
    signed_i = sg; size_i = sz; acc_i = acc; hi_i = hi; divisor_i = dv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R8 busy", {63'd0, busy_o}, 64'd1);
    if (poke) begin  // R9: restart while busy with other operands
      start_i = 1'b1; acc_i = ~acc; hi_i = 64'd0; divisor_i = 64'd3; signed_i = ~sg;
    end
    lat = 1;
    while (!done_o && lat < 100) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    start_i = 1'b0;
    chk(lat == exp_lat, poke ? "R7/R9 latency" : "R7 latency", 64'(lat), 64'(exp_lat));
    chk(div_err_o == err, re, {63'd0, div_err_o}, {63'd0, err});
    if (!err) begin
      chk(acc_o == acc_e, rv, acc_o, acc_e);
      chk(hi_o == hi_e, rv, hi_o, hi_e);
    end
    hold_a = acc_o; hold_h = hi_o;
    @(negedge clk_i);
    chk(!done_o && !busy_o && !div_err_o, "R8 pulse", {61'd0, done_o, busy_o, div_err_o}, 64'd0);
    acc_i = rnd(); divisor_i = rnd();
    @(negedge clk_i);
    chk(acc_o == hold_a && hi_o == hold_h, "R10 hold", acc_o, hold_a);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, h, d, m;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !div_err_o, "R8 reset", {61'd0, busy_o, done_o, div_err_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !div_err_o, "R8 idle", {61'd0, busy_o, done_o, div_err_o}, 64'd0);

    // R1, R3..R6: dense 8-bit sweep in both modes
    for (int sg = 0; sg < 2; sg++) begin
      for (int dd = 0; dd < 256; dd += 5) begin
        for (int k = 0; k < 24; k++) begin
          a = rnd();
          if (k == 0) a[15:0] = 16'h8000;
          if (k == 1) a[15:0] = 16'h7fff;
          if (k == 2) a[15:0] = 16'h0000;
          if (k == 3) a[15:0] = 16'hff80;
          if (k > 12) a[15:8] = a[15:8] >> (k - 12);
          run_op(sg[0], 2'd0, a, rnd(), {rnd() & 64'hffff_ffff_ffff_ff00} | 64'(dd), k == 5);
        end
      end
      foreach (a[i]) begin end
      run_op(sg[0], 2'd0, 64'h8000, 0, 64'hff, 0);
      run_op(sg[0], 2'd0, 64'hff80, 0, 64'hff, 0);
      run_op(sg[0], 2'd0, 64'hc000, 0, 64'h80, 0);
      run_op(sg[0], 2'd0, 64'h0080, 0, 64'h01, 0);
      run_op(sg[0], 2'd0, 64'hff80, 0, 64'h01, 0);
    end

    // R2, R3..R6: wider sizes, corners then pseudo-random
    for (int sz = 1; sz < 4; sz++) begin
      int n = 8 << sz;
      m = (n == 64) ? '1 : ((64'd1 << n) - 1);
      for (int sg = 0; sg < 2; sg++) begin
        run_op(sg[0], sz[1:0], 64'd1 << (n-1), m, m, 0);           // -2^(n-1) / -1
        run_op(sg[0], sz[1:0], 64'd1 << (n-1), m, 64'd1, 0);       // -2^(n-1) / 1
        run_op(sg[0], sz[1:0], 64'd1 << (n-1), 64'd0, 64'd1, 0);   // +2^(n-1) / 1
        run_op(sg[0], sz[1:0], rnd(), 64'd5, 64'd5, 0);            // hi == divisor
        run_op(sg[0], sz[1:0], rnd(), rnd(), ~m, 0);               // zero in low n bits
        run_op(sg[0], sz[1:0], m, m >> 1, m >> 1, 1);
        for (int k = 0; k < 100; k++) begin
          d = rnd() >> (rnd() % 64);
          if (d == 0) d = 64'd7;
          h = rnd();
          if (k % 3 != 0) h = h & ((d & m) >> 1);
          if (sg == 1 && k % 4 == 1) h = h | ~(m >> 1);
          a = rnd();
          run_op(sg[0], sz[1:0], a, h, d, k % 17 == 3);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule